// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits between the free-running internal clocks of a system clock generator and its output pins. It turns a set of stop requests into clean stops: an output may only end a high phase early by not starting the next one, and it always parks low. Three active-low request pins act on different groups of outputs. The CPU stop acts on the CPU clocks. The PCI stop acts on the stoppable PCI clocks and leaves one free-running PCI clock alone. Power-down acts on every output. Every output also has its own enable bit from the register file.

Each request is combined with its enable bit and then synchronized into the clock domain of the output it controls. The enable flop of a gate updates only while its source clock is low. A stop therefore lands at the end of the current high phase, and a restart begins with a full high phase. One selectable output carries either the 48 MHz-class clock or that clock divided by two. The choice comes from a strap input captured while reset is held. A two-bit mode field drives the pad tristate enable.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `cpu_stop_n` is low, both CPU outputs stay low, and the PCI, reference and 48 MHz-class outputs keep toggling.
- R2: While `pci_stop_n` is low, the four stoppable PCI outputs stay low, and `pci_free_out` keeps toggling.
- R3: While `pd_n` is low, every clock output stays low.
- R4: Each output has its own enable bit. A value of 1 lets the output toggle, and 0 holds that output low without affecting any other output.
- R5: `oe` is 0 in the same instant that `mode` equals 2'b11 (tristate). For 2'b00 (normal), 2'b01 (test) and 2'b10 (spread), `oe` is 1. `mode` has no effect on clock gating.
- R6: `strap_half` is sampled while `rst_n` is low. If it was 1, `sel_out` runs at half the `usb_clk` rate. If it was 0, `sel_out` runs at the full rate. Changes to `strap_half` after reset is released are ignored.
- R7: A stop request reaches its output within SYNC_STAGES source rising edges plus one falling edge. No high pulse on a gated output is shorter than half its source period.
- R8: When a stop is released, the first high pulse on the output is a full source high phase.
- R9: While `rst_n` is low, all clock outputs are held low and `oe` still follows `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal CPU clock source |
| pci_clk | input | 1 | Internal PCI clock source |
| ref_clk | input | 1 | Internal reference clock source |
| usb_clk | input | 1 | Internal 48 MHz-class clock source |
| rst_n | input | 1 | Active-low reset, applied synchronously in every domain |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU output stop |
| pci_stop_n | input | 1 | Asynchronous active-low stop for the stoppable PCI outputs |
| pd_n | input | 1 | Asynchronous active-low power-down, stops all outputs |
| strap_half | input | 1 | Strap: 1 selects half rate on `sel_out`, captured during reset |
| en_cpu | input | NCPU | Per-output CPU enable bits |
| en_pci | input | NPCI | Per-output enable bits for the stoppable PCI outputs |
| en_pci_free | input | 1 | Enable for the free-running PCI output |
| en_ref | input | NREF | Per-output reference enable bits |
| en_usb | input | 1 | Enable for the fixed 48 MHz-class output |
| en_sel | input | 1 | Enable for the selectable output |
| mode | input | 2 | Output mode: 00 normal, 01 test, 10 spread, 11 tristate |
| cpu_out | output | NCPU | Gated CPU clocks |
| pci_out | output | NPCI | Gated stoppable PCI clocks |
| pci_free_out | output | 1 | Gated free-running PCI clock |
| ref_out | output | NREF | Gated reference clocks |
| usb_out | output | 1 | Gated fixed 48 MHz-class clock |
| sel_out | output | 1 | Gated selectable clock, full or half rate |
| oe | output | 1 | Pad drive enable, 0 in tristate mode |

## Verification
The main stimulus is one request pin at a time. CPU stop, PCI stop and power-down are each asserted alone, and the bench counts edges on every output over a fixed window. This separates which group each request reaches and confirms the free PCI output is exempt. Enable masks with alternating bits show that each bit controls only its own output. The stop pins are also toggled rapidly at delays that drift against the source clocks, while every high pulse width is measured. This separates a gate that updates in the low phase from one that cuts a pulse short. Edge counts on the selectable output, measured after resets with each strap value, separate the half-rate path from the full-rate path.

// File: rtl/clk_stop_pkg.sv
// Shared definitions for the clock output stop controller.
// Assumes a two-bit output mode field whose encoding is fixed by the register file.
package clk_stop_pkg;

    typedef enum logic [1:0] {
        OUTMODE_RUN    = 2'b00,
        OUTMODE_TEST   = 2'b01,
        OUTMODE_SPREAD = 2'b10,
        OUTMODE_HIZ    = 2'b11
    } out_mode_e;

    // Smallest synchronizer depth the gates accept.
    localparam int SYNC_MIN = 2;

endpackage

// File: rtl/clkstop_sync.sv
// Multi-flop synchronizer that brings one asynchronous level into the clk domain.
// Assumes STAGES >= 2 and a slowly changing level input; a pulse narrower than a
// clock period may be lost.
module clkstop_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= {sh_q[STAGES-2:0], d};
        end
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
// Glitch-free clock gate: the request is synchronized on rising edges, and the
// enable is then captured on the falling edge, so it changes only while clk is
// low. The output is clk AND enable, so every high phase it passes is whole.
// Assumes clk has a roughly even duty cycle.
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic en_o,
    output logic clk_o
);

    logic run_s;
    logic en_q;

    clkstop_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run_req),
        .q     (run_s)
    );

    // Update the gate enable in the low phase only.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= run_s;
        end
    end

    assign en_o  = en_q;
    assign clk_o = clk & en_q;

endmodule

// File: rtl/clkstop_half.sv
// Half-rate output that can park: a toggle flop on the source clock. When the
// synchronized run level drops, the flop goes low at the next rising edge,
// which is the end of the current high phase, and stays low. A restart always
// begins with a full high phase. Assumes a free-running source clock.
module clkstop_half #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic en_o,
    output logic clk_o
);

    logic run_s;
    logic tog_q;

    clkstop_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run_req),
        .q     (run_s)
    );

    // Toggle while running, otherwise return to and hold the low level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (run_s) begin
            tog_q <= ~tog_q;
        end else begin
            tog_q <= 1'b0;
        end
    end

    assign en_o  = run_s;
    assign clk_o = tog_q;

endmodule

// File: rtl/clk_stop_ctrl.sv
// Clock output stop controller. Combines the asynchronous stop and power-down
// pins with the per-output enable bits, and gates each output in its own source
// domain so that it stops low after a whole high phase. Also captures the
// half-rate strap during reset and drives the pad enable from the mode field.
// Assumes free-running source clocks, including during reset.
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int NCPU        = 2,
    parameter int NPCI        = 4,
    parameter int NREF        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            cpu_clk,
    input  logic            pci_clk,
    input  logic            ref_clk,
    input  logic            usb_clk,
    input  logic            rst_n,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pd_n,
    input  logic            strap_half,
    input  logic [NCPU-1:0] en_cpu,
    input  logic [NPCI-1:0] en_pci,
    input  logic            en_pci_free,
    input  logic [NREF-1:0] en_ref,
    input  logic            en_usb,
    input  logic            en_sel,
    input  logic [1:0]      mode,
    output logic [NCPU-1:0] cpu_out,
    output logic [NPCI-1:0] pci_out,
    output logic            pci_free_out,
    output logic [NREF-1:0] ref_out,
    output logic            usb_out,
    output logic            sel_out,
    output logic            oe
);

    localparam int SYNC_N = (SYNC_STAGES < SYNC_MIN) ? SYNC_MIN : SYNC_STAGES;

    logic [NCPU-1:0] cpu_run;
    logic [NPCI-1:0] pci_run;
    logic [NREF-1:0] ref_run;
    logic [NCPU-1:0] cpu_en;
    logic [NPCI-1:0] pci_en;
    logic [NREF-1:0] ref_en;
    logic            pci_free_en;
    logic            usb_en;
    logic            sel_full_en;
    logic            sel_half_en;
    logic            sel_full_clk;
    logic            sel_half_clk;
    logic            strap_q;

    // Combine each group's stop sources with its enable bits.
    assign cpu_run = {NCPU{pd_n & cpu_stop_n}} & en_cpu;
    assign pci_run = {NPCI{pd_n & pci_stop_n}} & en_pci;
    assign ref_run = {NREF{pd_n}} & en_ref;

    // CPU outputs: one gate per output in the CPU domain.
    for (genvar gi = 0; gi < NCPU; gi++) begin : g_cpu
        clkstop_gate #(.SYNC_STAGES(SYNC_N)) u_gate (
            .clk     (cpu_clk),
            .rst_n   (rst_n),
            .run_req (cpu_run[gi]),
            .en_o    (cpu_en[gi]),
            .clk_o   (cpu_out[gi])
        );
    end

    // Stoppable PCI outputs.
    for (genvar gi = 0; gi < NPCI; gi++) begin : g_pci
        clkstop_gate #(.SYNC_STAGES(SYNC_N)) u_gate (
            .clk     (pci_clk),
            .rst_n   (rst_n),
            .run_req (pci_run[gi]),
            .en_o    (pci_en[gi]),
            .clk_o   (pci_out[gi])
        );
    end

    // Free-running PCI output: not subject to the PCI stop pin.
    clkstop_gate #(.SYNC_STAGES(SYNC_N)) u_pci_free (
        .clk     (pci_clk),
        .rst_n   (rst_n),
        .run_req (pd_n & en_pci_free),
        .en_o    (pci_free_en),
        .clk_o   (pci_free_out)
    );

    // Reference outputs.
    for (genvar gi = 0; gi < NREF; gi++) begin : g_ref
        clkstop_gate #(.SYNC_STAGES(SYNC_N)) u_gate (
            .clk     (ref_clk),
            .rst_n   (rst_n),
            .run_req (ref_run[gi]),
            .en_o    (ref_en[gi]),
            .clk_o   (ref_out[gi])
        );
    end

    // Fixed 48 MHz-class output.
    clkstop_gate #(.SYNC_STAGES(SYNC_N)) u_usb (
        .clk     (usb_clk),
        .rst_n   (rst_n),
        .run_req (pd_n & en_usb),
        .en_o    (usb_en),
        .clk_o   (usb_out)
    );

    // Selectable output, full-rate path.
    clkstop_gate #(.SYNC_STAGES(SYNC_N)) u_sel_full (
        .clk     (usb_clk),
        .rst_n   (rst_n),
        .run_req (pd_n & en_sel),
        .en_o    (sel_full_en),
        .clk_o   (sel_full_clk)
    );

    // Selectable output, half-rate path.
    clkstop_half #(.SYNC_STAGES(SYNC_N)) u_sel_half (
        .clk     (usb_clk),
        .rst_n   (rst_n),
        .run_req (pd_n & en_sel),
        .en_o    (sel_half_en),
        .clk_o   (sel_half_clk)
    );

    // Capture the strap while reset is held, then hold it.
    always_ff @(posedge usb_clk) begin
        if (!rst_n) begin
            strap_q <= strap_half;
        end
    end

    // The strap is static after reset, so this selection never switches at run time.
    assign sel_out = strap_q ? sel_half_clk : sel_full_clk;

    // Tristate mode releases the pads immediately, whatever the gates are doing.
    assign oe = (out_mode_e'(mode) != OUTMODE_HIZ);

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
// Property checker for the clock output stop controller. Saturating counters
// measure how long each request has been held, so the check window does not
// depend on unrolling a parameter. Bound into every instance of the top module.
module clk_stop_ctrl_chk #(
    parameter int NCPU        = 2,
    parameter int NREF        = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic            cpu_clk,
    input logic            pci_clk,
    input logic            ref_clk,
    input logic            usb_clk,
    input logic            rst_n,
    input logic            cpu_stop_n,
    input logic            pd_n,
    input logic            en_pci_free,
    input logic [1:0]      mode,
    input logic            oe,
    input logic [NCPU-1:0] cpu_en,
    input logic            pci_free_en,
    input logic [NREF-1:0] ref_en,
    input logic            strap_q
);

    localparam int            LIM  = SYNC_STAGES + 2;
    localparam int            CW   = $clog2(LIM + 1);
    localparam logic [CW-1:0] LIMV = CW'(LIM);

    logic [CW-1:0] cstop_cnt;
    logic [CW-1:0] free_cnt;
    logic [CW-1:0] pd_cnt;

    // Count CPU clock edges for which the CPU stop has been held low.
    always_ff @(posedge cpu_clk) begin
        if (!rst_n || cpu_stop_n) begin
            cstop_cnt <= '0;
        end else if (cstop_cnt != LIMV) begin
            cstop_cnt <= cstop_cnt + 1'b1;
        end
    end

    // Count PCI clock edges for which the free PCI output has been allowed to run.
    always_ff @(posedge pci_clk) begin
        if (!rst_n || !(pd_n && en_pci_free)) begin
            free_cnt <= '0;
        end else if (free_cnt != LIMV) begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

    // Count reference clock edges for which power-down has been held low.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || pd_n) begin
            pd_cnt <= '0;
        end else if (pd_cnt != LIMV) begin
            pd_cnt <= pd_cnt + 1'b1;
        end
    end

    // R1
    cpu_stop_low_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (cstop_cnt == LIMV) |-> (cpu_en == '0));

    // R2
    pci_free_run_chk: assert property (@(posedge pci_clk) disable iff (!rst_n)
        (free_cnt == LIMV) |-> pci_free_en);

    // R3
    pd_ref_low_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (pd_cnt == LIMV) |-> (ref_en == '0));

    // R5
    hiz_release_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !oe);

    // R6
    strap_hold_chk: assert property (@(posedge usb_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
    .NCPU        (NCPU),
    .NREF        (NREF),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .cpu_clk     (cpu_clk),
    .pci_clk     (pci_clk),
    .ref_clk     (ref_clk),
    .usb_clk     (usb_clk),
    .rst_n       (rst_n),
    .cpu_stop_n  (cpu_stop_n),
    .pd_n        (pd_n),
    .en_pci_free (en_pci_free),
    .mode        (mode),
    .oe          (oe),
    .cpu_en      (cpu_en),
    .pci_free_en (pci_free_en),
    .ref_en      (ref_en),
    .strap_q     (strap_q)
);

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues expected output behaviour, and the
// monitor pops each item and measures the matching output over a time window.
module clk_stop_ctrl_tb_top;

    localparam int NCPU = 2;
    localparam int NPCI = 4;
    localparam int NREF = 2;

    logic cpu_clk = 1'b0;
    logic pci_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic usb_clk = 1'b0;

    always #2  cpu_clk = ~cpu_clk;   // 250 MHz
    always #6  pci_clk = ~pci_clk;
    always #14 ref_clk = ~ref_clk;
    always #4  usb_clk = ~usb_clk;

    logic            rst_n;
    logic            cpu_stop_n, pci_stop_n, pd_n, strap_half;
    logic [NCPU-1:0] en_cpu;
    logic [NPCI-1:0] en_pci;
    logic            en_pci_free, en_usb, en_sel;
    logic [NREF-1:0] en_ref;
    logic [1:0]      mode;
    logic [NCPU-1:0] cpu_out;
    logic [NPCI-1:0] pci_out;
    logic            pci_free_out, usb_out, sel_out, oe;
    logic [NREF-1:0] ref_out;

    clk_stop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .NREF(NREF), .SYNC_STAGES(2)) dut_i (
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .ref_clk(ref_clk), .usb_clk(usb_clk),
        .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pd_n(pd_n),
        .strap_half(strap_half), .en_cpu(en_cpu), .en_pci(en_pci),
        .en_pci_free(en_pci_free), .en_ref(en_ref), .en_usb(en_usb), .en_sel(en_sel),
        .mode(mode), .cpu_out(cpu_out), .pci_out(pci_out), .pci_free_out(pci_free_out),
        .ref_out(ref_out), .usb_out(usb_out), .sel_out(sel_out), .oe(oe)
    );

    // Output index map: 0-1 CPU, 2-5 PCI, 6 free PCI, 7-8 REF, 9 fixed 48, 10 selectable.
    // Kinds: 0 run/stop over a window, 1 selectable rate, 2 oe level, 3 runt count.
    typedef struct {
        string tag;
        int    idx;
        int    kind;
        bit    exp;
    } item_t;

    item_t q[$];
    int    pending = 0;
    bit    busy    = 1'b0;
    int    checks  = 0;
    int    errors  = 0;
    bit    done    = 1'b0;
    int    edges [11];
    int    runts [2];
    real   t_rise_cpu = 0.0;
    real   t_rise_pci = 0.0;

    initial begin
        for (int i = 0; i < 11; i++) edges[i] = 0;
        runts[0] = 0;
        runts[1] = 0;
    end

    always @(posedge cpu_out[0])    edges[0]++;
    always @(posedge cpu_out[1])    edges[1]++;
    always @(posedge pci_out[0])    edges[2]++;
    always @(posedge pci_out[1])    edges[3]++;
    always @(posedge pci_out[2])    edges[4]++;
    always @(posedge pci_out[3])    edges[5]++;
    always @(posedge pci_free_out)  edges[6]++;
    always @(posedge ref_out[0])    edges[7]++;
    always @(posedge ref_out[1])    edges[8]++;
    always @(posedge usb_out)       edges[9]++;
    always @(posedge sel_out)       edges[10]++;

    // Measure high pulse widths of one CPU and one PCI output.
    always @(posedge cpu_out[0]) t_rise_cpu = $realtime;
    always @(negedge cpu_out[0]) if (rst_n === 1'b1 && ($realtime - t_rise_cpu) < 1.9) runts[0]++;
    always @(posedge pci_out[0]) t_rise_pci = $realtime;
    always @(negedge pci_out[0]) if (rst_n === 1'b1 && ($realtime - t_rise_pci) < 5.9) runts[1]++;

    function automatic logic level(int idx);
        if (idx < 2)       return cpu_out[idx];
        else if (idx < 6)  return pci_out[idx-2];
        else if (idx == 6) return pci_free_out;
        else if (idx < 9)  return ref_out[idx-7];
        else if (idx == 9) return usb_out;
        else               return sel_out;
    endfunction

    task automatic expect_item(string tag, int idx, int kind, bit exp);
        item_t it;
        it.tag  = tag;
        it.idx  = idx;
        it.kind = kind;
        it.exp  = exp;
        q.push_back(it);
        pending++;
    endtask

    task automatic drain();
        wait (pending == 0 && busy == 1'b0);
    endtask

    // Monitor: pop each expected item and compare it with measured output behaviour.
    initial begin
        forever begin
            item_t it;
            int    c0;
            int    d;
            bit    ok;
            wait (pending > 0);
            busy = 1'b1;
            it = q.pop_front();
            pending--;
            ok = 1'b1;
            d  = 0;
            case (it.kind)
                0: begin
                    c0 = edges[it.idx];
                    #320;
                    d  = edges[it.idx] - c0;
                    ok = it.exp ? (d > 0) : (d == 0 && level(it.idx) == 1'b0);
                end
                1: begin
                    c0 = edges[it.idx];
                    #320;
                    d  = edges[it.idx] - c0;
                    ok = it.exp ? (d >= 17 && d <= 23) : (d >= 37 && d <= 43);
                end
                2: begin
                    #0.5;
                    d  = int'(oe);
                    ok = (oe == it.exp);
                end
                default: begin
                    d  = runts[it.idx];
                    ok = (d == 0);
                end
            endcase
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s idx=%0d kind=%0d actual=%0d expected=%0d",
                         it.tag, it.idx, it.kind, d, it.exp);
            end
            busy = 1'b0;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            finish_run();
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pd_n = 1'b1;
        strap_half = 1'b1; en_cpu = '1; en_pci = '1; en_pci_free = 1'b1;
        en_ref = '1; en_usb = 1'b1; en_sel = 1'b1; mode = 2'b00;
        #1.3;

        // R9: outputs held low during reset, oe follows mode
        expect_item("R9 cpu in reset", 0, 0, 1'b0);
        expect_item("R9 pci in reset", 2, 0, 1'b0);
        expect_item("R9 ref in reset", 7, 0, 1'b0);
        expect_item("R9 sel in reset", 10, 0, 1'b0);
        expect_item("R9 oe in reset", 0, 2, 1'b1);
        drain();
        rst_n = 1'b1;
        #200;

        // R4: everything enabled runs; R6: strap 1 gives half rate
        for (int i = 0; i < 11; i++) expect_item("R4 all enabled", i, 0, 1'b1);
        expect_item("R6 half rate", 10, 1, 1'b1);
        drain();

        // R1: CPU stop
        cpu_stop_n = 1'b0;
        #100;
        expect_item("R1 cpu0 stopped", 0, 0, 1'b0);
        expect_item("R1 cpu1 stopped", 1, 0, 1'b0);
        expect_item("R1 pci runs", 2, 0, 1'b1);
        expect_item("R1 ref runs", 7, 0, 1'b1);
        expect_item("R1 usb runs", 9, 0, 1'b1);
        drain();
        cpu_stop_n = 1'b1;
        #100;
        expect_item("R1 cpu0 resumes", 0, 0, 1'b1);
        drain();

        // R2: PCI stop leaves the free output running
        pci_stop_n = 1'b0;
        #150;
        for (int i = 2; i < 6; i++) expect_item("R2 pci stopped", i, 0, 1'b0);
        expect_item("R2 free pci runs", 6, 0, 1'b1);
        expect_item("R2 cpu runs", 0, 0, 1'b1);
        drain();
        pci_stop_n = 1'b1;
        #150;

        // R3: power-down stops everything
        pd_n = 1'b0;
        #300;
        for (int i = 0; i < 11; i++) expect_item("R3 power-down", i, 0, 1'b0);
        drain();
        pd_n = 1'b1;
        #300;
        expect_item("R3 ref resumes", 8, 0, 1'b1);
        drain();

        // R4: per-output enable bits
        en_cpu = 2'b10; en_pci = 4'b0101; en_ref = 2'b01;
        en_usb = 1'b0; en_sel = 1'b0; en_pci_free = 1'b0;
        #300;
        expect_item("R4 cpu0 disabled", 0, 0, 1'b0);
        expect_item("R4 cpu1 enabled", 1, 0, 1'b1);
        expect_item("R4 pci0 enabled", 2, 0, 1'b1);
        expect_item("R4 pci1 disabled", 3, 0, 1'b0);
        expect_item("R4 pci3 disabled", 5, 0, 1'b0);
        expect_item("R4 free disabled", 6, 0, 1'b0);
        expect_item("R4 ref0 enabled", 7, 0, 1'b1);
        expect_item("R4 ref1 disabled", 8, 0, 1'b0);
        expect_item("R4 usb disabled", 9, 0, 1'b0);
        expect_item("R4 sel disabled", 10, 0, 1'b0);
        drain();
        en_cpu = '1; en_pci = '1; en_ref = '1; en_usb = 1'b1; en_sel = 1'b1; en_pci_free = 1'b1;
        #300;

        // R5: mode field and pad enable
        mode = 2'b11;
        expect_item("R5 tristate oe", 0, 2, 1'b0);
        expect_item("R5 gating unchanged", 0, 0, 1'b1);
        drain();
        mode = 2'b01;
        expect_item("R5 test oe", 0, 2, 1'b1);
        drain();
        mode = 2'b10;
        expect_item("R5 spread oe", 0, 2, 1'b1);
        expect_item("R5 spread sel rate", 10, 1, 1'b1);
        drain();
        mode = 2'b00;

        // R7: stop latency bounded by the synchronizer depth
        cpu_stop_n = 1'b0;
        #14;
        expect_item("R7 cpu stop latency", 0, 0, 1'b0);
        drain();
        cpu_stop_n = 1'b1;
        #100;

        // R7 R8: rapid stop toggling at drifting offsets, no short high pulses
        for (int i = 0; i < 60; i++) begin
            cpu_stop_n = ~cpu_stop_n;
            pci_stop_n = ~pci_stop_n;
            #(3.1 + (i % 7) * 2.3);
        end
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        #200;
        expect_item("R7 R8 cpu pulse widths", 0, 3, 1'b0);
        expect_item("R7 R8 pci pulse widths", 1, 3, 1'b0);
        drain();

        // R6: strap change after reset has no effect
        strap_half = 1'b0;
        #100;
        expect_item("R6 strap ignored", 10, 1, 1'b1);
        drain();

        // R6: new reset with strap low gives full rate
        rst_n = 1'b0;
        #200;
        rst_n = 1'b1;
        #200;
        expect_item("R6 full rate", 10, 1, 1'b0);
        expect_item("R9 usb after reset", 9, 0, 1'b1);
        drain();

        finish_run();
    end

endmodule